// File: doc/BRIEF.md
# Snapshot-Latched Monitoring Counters

This block keeps a bank of live event counters for a front-end data path. One counter tracks crossings for which both a header and a payload went out, one tracks truncated events, and one more tracks each type of received timing command. All of them can be cleared together by the event counter reset; the bunch counter lives elsewhere and is not touched.

Because software reads the counts slowly, one word at a time, it must never see values taken at different moments. A snapshot strobe therefore copies every live count into a shadow bank in the same clock edge, and the read port only ever returns shadow values. A snapshot can be asked for once, through a strobe input, or it can come from an internal timer that fires every programmed number of clock cycles.

Top module: `mon_snapshot_counters`

## Requirements
- R1: The accepted counter (read index 0) goes up by one for each cycle with `evt_valid` high and `evt_hdr_only` low. A cycle with `evt_hdr_only` high is not counted.
- R2: The truncation counter (read index 1) goes up by one for each cycle with `evt_trunc` high.
- R3: Command counter k (read index 2+k) goes up by one for each cycle in which bit k of `cmd_strobe` is high. Several bits may be high in the same cycle.
- R4: A cycle with `evt_cnt_rst` high sets every live counter to 0, so a later snapshot reads 0 at every index.
- R5: When `evt_cnt_rst` and an increment occur in the same cycle, the counter becomes 0 and the increment is lost.
- R6: A counter that reaches 2^CNT_W-1 stays at that value and does not wrap.
- R7: A snapshot copies all live counts into the shadow bank on one edge, and `snap_done` is high in the following cycle. Between snapshots, `rd_data` does not change, even while the live counts move.
- R8: When a snapshot and `evt_cnt_rst` occur in the same cycle, the shadow bank takes the values from before the reset.
- R9: Writing period P>0 with `per_wr` makes a snapshot every P cycles. The first snapshot comes at the P-th edge after the write edge. Writing P=0 turns the periodic snapshot off.
- R10: Each period write restarts the timer, so no snapshot is due from an earlier write.
- R11: After `rst_n` is low, every shadow word and every live counter reads 0. A `rd_addr` at or above 2+NUM_CMD returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | One event left the front end this cycle |
| evt_hdr_only | input | 1 | That event carried only its header |
| evt_trunc | input | 1 | One event was truncated this cycle |
| cmd_strobe | input | NUM_CMD | One strobe per timing command type |
| evt_cnt_rst | input | 1 | Event counter reset: clears all live counters |
| snap_req | input | 1 | Single-shot snapshot request |
| per_wr | input | 1 | Write strobe for the snapshot period |
| per_val | input | PER_W | New snapshot period in cycles; 0 turns it off |
| rd_addr | input | ADDR_W | Shadow word select |
| rd_data | output | CNT_W | Selected shadow word |
| snap_done | output | 1 | High for one cycle after each snapshot |

## Verification
The counters are driven with plain accepted events, header-only events, truncations, and command strobes that use single bits and several bits at once. This separates the header-only filter from the command index mapping. Reads taken before and after a snapshot, with the live counts moving in between, show whether the read port really reads the shadow bank. Reset is issued in the same cycle as increments and, separately, in the same cycle as a snapshot; this shows which input takes priority in each pairing. The timer is checked by the cycle positions of `snap_done` for a single period write, for a write repeated early, and for period zero.

// File: rtl/mon_pkg.sv
// Shared constants for the monitoring counter bank.
// Assumes the read map puts the two event counters first, then one word per command type.
package mon_pkg;
    localparam int IDX_ACC   = 0;
    localparam int IDX_TRUNC = 1;
    localparam int IDX_CMD0  = 2;
    localparam int NUM_EVT   = 2;
endpackage

// File: rtl/mon_sat_counter.sv
// Single saturating event counter with a synchronous clear.
// Assumes clr takes priority over inc, and that the count stops at all ones.
module mon_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    // Count up on inc, hold at MAX, go to zero on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc && cnt != MAX)
            cnt <= cnt + 1'b1;
    end

    p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAX && !clr) |=> cnt == MAX);
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && cnt != MAX) |=> cnt == $past(cnt) + 1'b1);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt));
endmodule

// File: rtl/mon_snap_timer.sv
// Periodic snapshot timer: pulses tick once every per_q cycles.
// Assumes a period of 0 disables it, and that a write restarts the count and
// suppresses a tick in the same cycle.
module mon_snap_timer #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          per_wr,
    input  logic [PW-1:0] per_val,
    output logic          tick
);
    logic [PW-1:0] per_q;
    logic [PW-1:0] tmr;

    // Tick when the count reaches the last cycle of the period.
    always_comb tick = (per_q != '0) && (tmr == per_q - 1'b1) && !per_wr;

    // Hold the period and advance the cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
            tmr   <= '0;
        end else if (per_wr) begin
            per_q <= per_val;
            tmr   <= '0;
        end else if (per_q == '0 || tick) begin
            tmr   <= '0;
        end else begin
            tmr   <= tmr + 1'b1;
        end
    end

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr |=> tmr == '0);
    p_tmr_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q != '0) |-> tmr < per_q);
    p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && per_q > 1 && !per_wr) |=> !tick);
endmodule

// File: rtl/mon_snapshot_counters.sv
// Bank of live monitoring counters with a shadow copy that is taken all at once.
// Assumes the read port is slow and reads only the shadow bank. The event counter
// reset clears the live counters only; a snapshot in the same cycle sees the
// values from before the reset.
module mon_snapshot_counters
    import mon_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_CMD = 4,
    parameter int PER_W   = 24,
    parameter int ADDR_W  = $clog2(NUM_EVT + NUM_CMD)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid,
    input  logic               evt_hdr_only,
    input  logic               evt_trunc,
    input  logic [NUM_CMD-1:0] cmd_strobe,
    input  logic               evt_cnt_rst,
    input  logic               snap_req,
    input  logic               per_wr,
    input  logic [PER_W-1:0]   per_val,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [CNT_W-1:0]   rd_data,
    output logic               snap_done
);
    localparam int NUM_CNT = NUM_EVT + NUM_CMD;

    logic [NUM_CNT-1:0] inc;
    logic [CNT_W-1:0]   cnt_q  [NUM_CNT];
    logic [CNT_W-1:0]   shadow [NUM_CNT];
    logic               tick;
    logic               snap;

    // Map each event source onto its counter index.
    always_comb begin
        inc[IDX_ACC]   = evt_valid && !evt_hdr_only;
        inc[IDX_TRUNC] = evt_trunc;
    end

    for (genvar k = 0; k < NUM_CMD; k++) begin : g_cmd_inc
        assign inc[IDX_CMD0 + k] = cmd_strobe[k];
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        mon_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (evt_cnt_rst),
            .inc   (inc[i]),
            .cnt   (cnt_q[i])
        );
    end

    mon_snap_timer #(.PW(PER_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .per_wr  (per_wr),
        .per_val (per_val),
        .tick    (tick)
    );

    // A snapshot comes from the single-shot strobe or from the timer.
    always_comb snap = snap_req || tick;

    // Copy every live count into the shadow bank on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CNT; i++) shadow[i] <= '0;
            snap_done <= 1'b0;
        end else begin
            if (snap)
                for (int i = 0; i < NUM_CNT; i++) shadow[i] <= cnt_q[i];
            snap_done <= snap;
        end
    end

    // Select one shadow word; addresses past the bank read zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CNT; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = shadow[i];
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        p_snap_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
            snap |=> shadow[i] == $past(cnt_q[i]));
        p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !snap |=> $stable(shadow[i]));
    end

    p_hdr_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_hdr_only && !evt_cnt_rst) |=> cnt_q[IDX_ACC] == $past(cnt_q[IDX_ACC]));
    p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> snap_done);
endmodule

// File: tb/sim_mon_snapshot_counters.sv
module sim_mon_snapshot_counters;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W   = 6;
    localparam int NUM_CMD = 4;
    localparam int PER_W   = 8;
    localparam int ADDR_W  = 3;
    localparam int MAXV    = (1 << CNT_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               evt_valid = 1'b0, evt_hdr_only = 1'b0, evt_trunc = 1'b0;
    logic [NUM_CMD-1:0] cmd_strobe = '0;
    logic               evt_cnt_rst = 1'b0, snap_req = 1'b0, per_wr = 1'b0;
    logic [PER_W-1:0]   per_val = '0;
    logic [ADDR_W-1:0]  rd_addr = '0;
    logic [CNT_W-1:0]   rd_data;
    logic               snap_done;

    int n_checks = 0;
    int n_fail   = 0;
    int n_pushed = 0;
    int n_done   = 0;

    typedef struct {
        int    addr;
        int    exp;
        string req;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mon_snapshot_counters #(
        .CNT_W(CNT_W), .NUM_CMD(NUM_CMD), .PER_W(PER_W), .ADDR_W(ADDR_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_hdr_only(evt_hdr_only),
        .evt_trunc(evt_trunc), .cmd_strobe(cmd_strobe), .evt_cnt_rst(evt_cnt_rst),
        .snap_req(snap_req), .per_wr(per_wr), .per_val(per_val),
        .rd_addr(rd_addr), .rd_data(rd_data), .snap_done(snap_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected reads and compares them with the port.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                rd_addr = ADDR_W'(it.addr);
                #1;
                check(int'(rd_data) == it.exp, it.req, int'(rd_data), it.exp);
                n_done++;
            end
        end
    end

    // Driver side: queue one expected read, wait until it is compared.
    task automatic expect_rd(input int addr, input int exp, input string req);
        item_t it;
        it.addr = addr; it.exp = exp; it.req = req;
        sb_q.push_back(it);
        n_pushed++;
        wait (n_done == n_pushed);
        @(negedge clk);
    endtask

    // Drive one cycle of inputs from a negedge and return at the next negedge.
    task automatic drv(input bit ev, input bit hd, input bit tr, input logic [NUM_CMD-1:0] cm,
                       input bit rs, input bit sn);
        evt_valid = ev; evt_hdr_only = hd; evt_trunc = tr; cmd_strobe = cm;
        evt_cnt_rst = rs; snap_req = sn;
        @(negedge clk);
        evt_valid = 1'b0; evt_hdr_only = 1'b0; evt_trunc = 1'b0; cmd_strobe = '0;
        evt_cnt_rst = 1'b0; snap_req = 1'b0;
    endtask

    task automatic write_period(input int p);
        per_wr = 1'b1; per_val = PER_W'(p);
        @(negedge clk);
        per_wr = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state and reads past the bank
        for (int a = 0; a < 6; a++) expect_rd(a, 0, "R11 reset");
        check(snap_done == 1'b0, "R11 snap_done reset", int'(snap_done), 0);

        // R1, R2, R3: mixed increments
        repeat (3) drv(1, 0, 0, 4'b0000, 0, 0);
        repeat (2) drv(1, 1, 0, 4'b0000, 0, 0);
        repeat (2) drv(0, 0, 1, 4'b0000, 0, 0);
        drv(0, 0, 0, 4'b0001, 0, 0);
        repeat (2) drv(0, 0, 0, 4'b0110, 0, 0);
        drv(0, 0, 0, 4'b1111, 0, 0);
        expect_rd(0, 0, "R7 shadow not yet latched");
        drv(0, 0, 0, 4'b0000, 0, 1);
        check(snap_done == 1'b1, "R7 snap_done", int'(snap_done), 1);
        expect_rd(0, 3, "R1 accepted, header-only skipped");
        expect_rd(1, 2, "R2 truncated");
        expect_rd(2, 2, "R3 cmd0");
        expect_rd(3, 3, "R3 cmd1");
        expect_rd(4, 3, "R3 cmd2");
        expect_rd(5, 1, "R3 cmd3");

        // R7, R8, R4
        drv(1, 0, 0, 4'b0000, 0, 0);
        expect_rd(0, 3, "R7 shadow holds while live moves");
        drv(0, 0, 0, 4'b0000, 1, 1);
        expect_rd(0, 4, "R8 pre-reset accepted");
        expect_rd(3, 3, "R8 pre-reset cmd1");
        drv(0, 0, 0, 4'b0000, 0, 1);
        expect_rd(0, 0, "R4 accepted cleared");
        expect_rd(1, 0, "R4 truncated cleared");
        expect_rd(5, 0, "R4 cmd3 cleared");

        // R5: reset with increments in the same cycle
        drv(1, 0, 1, 4'b1111, 1, 0);
        drv(0, 0, 0, 4'b0000, 0, 1);
        expect_rd(0, 0, "R5 accepted dropped");
        expect_rd(1, 0, "R5 truncated dropped");
        expect_rd(2, 0, "R5 cmd0 dropped");

        // R6: saturation
        repeat (MAXV + 7) drv(1, 0, 0, 4'b0000, 0, 0);
        drv(0, 0, 0, 4'b0000, 0, 1);
        expect_rd(0, MAXV, "R6 saturated");
        drv(1, 0, 0, 4'b0000, 0, 0);
        drv(0, 0, 0, 4'b0000, 0, 1);
        expect_rd(0, MAXV, "R6 no wrap");
        drv(0, 0, 0, 4'b0000, 1, 0);

        // R9: periodic snapshot
        repeat (2) drv(0, 0, 0, 4'b1000, 0, 0);
        expect_rd(5, 0, "R7 cmd3 not latched");
        write_period(5);
        for (int k = 1; k <= 11; k++) begin
            @(negedge clk);
            check(snap_done == ((k == 5) || (k == 10)), "R9 periodic pulse",
                  int'(snap_done), int'((k == 5) || (k == 10)));
        end
        write_period(0);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            check(snap_done == 1'b0, "R9 period zero", int'(snap_done), 0);
        end
        expect_rd(5, 2, "R9 periodic latched cmd3");

        // R10: rewrite restarts the timer
        write_period(5);
        repeat (2) @(negedge clk);
        write_period(5);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            check(snap_done == (k == 5), "R10 restart", int'(snap_done), int'(k == 5));
        end
        write_period(0);

        // R11: addresses past the bank
        expect_rd(6, 0, "R11 addr 6");
        expect_rd(7, 0, "R11 addr 7");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule